// File: doc/BRIEF.md
# Lockable Configuration Register Bank

This block is a small byte-addressed register bank that also decides whether other storage may be written. It holds three locations. The first is a user identification byte that software may read and write. The second is a protection register with two lock bits. The third is a read-only revision code that is fixed when the block is built.

Software writes the protection register in toggle fashion: a 1 in a bit position flips that bit, and a 0 leaves it alone. The protection register stays writable even while every other configuration location is frozen. One of its bits is also set by hardware whenever the fault logger reports that a log has been taken.

The neighbouring storage offers each write it intends to make on a request port. The bank answers in the same cycle with a write-permit. The permit is withheld when the target lies in the protected fault-log range and the fault flag is set. It is also withheld when the target lies in the configuration range, other than the protection register, and the configuration lock is set.

Top module: `lockable_cfg_bank`

## Requirements
- R1: After synchronous reset the identification byte and both lock bits are 0, so reads of addresses 5Ch and 5Dh return 00h.
- R2: With the configuration lock (bit 0 of 5Dh) clear, a write to 5Ch loads the byte, and it is returned by a read from the cycle after the accepting clock edge.
- R3: With the configuration lock set, writes to 5Ch are ignored and the stored byte is kept.
- R4: A write to 5Dh flips each of bits 0 and 1 whose written value is 1 and keeps each whose written value is 0; this works whether or not the configuration lock is set.
- R5: A pulse on the fault-log strobe sets bit 1 of 5Dh at the next clock edge; if a toggle write to that bit falls in the same cycle, the bit still ends up set.
- R6: A read of 65h returns the revision parameter in bits [2:0]; writes to 65h change nothing.
- R7: Bits [7:2] of 5Dh and [7:3] of 65h read 0, and any address other than 5Ch, 5Dh and 65h reads 00h.
- R8: A storage request to 00h..11h is refused (permit low) while bit 1 of 5Dh is 1, and granted while it is 0.
- R9: A storage request into the configuration range (default 20h..6Fh) other than 5Dh is refused while bit 0 of 5Dh is 1; a request to 5Dh is always granted.
- R10: The permit is combinational on the request in the same cycle, is low whenever no request is made, and is high for requests outside both guarded ranges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write enable, sampled at the rising edge |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| fault_log_hit | input | 1 | One-cycle strobe from the fault logger |
| nv_addr | input | 8 | Address of a pending storage write |
| nv_req | input | 1 | Storage write request |
| nv_permit | output | 1 | Grant for the pending storage write |

## Verification
Both outputs are combinational views. The read data follows the stored state, and that state changes only at the rising edge, so a write or strobe presented in one cycle shows up on a read during the next cycle. The permit follows the request in the same cycle and depends on the lock bits as they stood before that cycle's edge. The bench applies every stimulus just after the falling edge and samples both outputs 2 ns later. It compares them against a model that still holds the pre-edge state, and it advances the model only after the rising edge. Each write's result is therefore checked by the read of the following step.

// File: rtl/lkb_pkg.sv
package lkb_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int REV_W  = 3;

    localparam logic [ADDR_W-1:0] ADDR_ID   = 8'h5C;
    localparam logic [ADDR_W-1:0] ADDR_LOCK = 8'h5D;
    localparam logic [ADDR_W-1:0] ADDR_REV  = 8'h65;

    typedef struct packed {
        logic flt_lock;
        logic cfg_lock;
    } lock_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              we;
    } wr_t;

    function automatic logic in_span(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] lo,
                                     input logic [ADDR_W-1:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction
endpackage

// File: rtl/lkb_lock_reg.sv
module lkb_lock_reg
    import lkb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lock_we,
    input  logic [1:0] lock_wd,
    input  logic       flt_trig,
    output lock_t      lock_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= '0;
        end else begin
            lock_q.cfg_lock <= lock_q.cfg_lock ^ (lock_we & lock_wd[0]);
            lock_q.flt_lock <= flt_trig | (lock_q.flt_lock ^ (lock_we & lock_wd[1]));
        end
    end

    assert_fault_sets_flag_R5: assert property (@(posedge clk) disable iff (rst)
        flt_trig |=> lock_q.flt_lock);
    assert_zero_keeps_cfg_R4: assert property (@(posedge clk) disable iff (rst)
        (lock_we && !lock_wd[0]) |=> $stable(lock_q.cfg_lock));
    assert_one_flips_cfg_R4: assert property (@(posedge clk) disable iff (rst)
        (lock_we && lock_wd[0]) |=> (lock_q.cfg_lock != $past(lock_q.cfg_lock)));
    assert_idle_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (!lock_we && !flt_trig) |=> $stable(lock_q));
endmodule

// File: rtl/lkb_id_reg.sv
module lkb_id_reg
    import lkb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_t               wr,
    input  logic              cfg_lock,
    output logic [DATA_W-1:0] id_q
);
    logic hit;
    assign hit = wr.we && (wr.addr == ADDR_ID);

    always_ff @(posedge clk) begin
        if (rst)
            id_q <= '0;
        else if (hit && !cfg_lock)
            id_q <= wr.data;
    end

    assert_locked_id_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (hit && cfg_lock) |=> $stable(id_q));
    assert_open_id_loads_R2: assert property (@(posedge clk) disable iff (rst)
        (hit && !cfg_lock) |=> (id_q == $past(wr.data)));
endmodule

// File: rtl/lkb_guard.sv
module lkb_guard
    import lkb_pkg::*;
#(
    parameter logic [ADDR_W-1:0] FLT_LO = 8'h00,
    parameter logic [ADDR_W-1:0] FLT_HI = 8'h11,
    parameter logic [ADDR_W-1:0] CFG_LO = 8'h20,
    parameter logic [ADDR_W-1:0] CFG_HI = 8'h6F
) (
    input  logic              clk,
    input  logic              rst,
    input  lock_t             lock_q,
    input  logic [ADDR_W-1:0] nv_addr,
    input  logic              nv_req,
    output logic              nv_permit
);
    logic in_flt, in_cfg, blocked;

    always_comb begin
        in_flt  = in_span(nv_addr, FLT_LO, FLT_HI);
        in_cfg  = in_span(nv_addr, CFG_LO, CFG_HI) && (nv_addr != ADDR_LOCK);
        blocked = (in_flt && lock_q.flt_lock) || (in_cfg && lock_q.cfg_lock);
        nv_permit = nv_req && !blocked;
    end

    assert_flt_refused_R8: assert property (@(posedge clk) disable iff (rst)
        (nv_req && nv_addr <= FLT_HI && lock_q.flt_lock) |-> !nv_permit);
    assert_lockreg_open_R9: assert property (@(posedge clk) disable iff (rst)
        (nv_req && nv_addr == ADDR_LOCK) |-> nv_permit);
    assert_idle_no_permit_R10: assert property (@(posedge clk) disable iff (rst)
        !nv_req |-> !nv_permit);
endmodule

// File: rtl/lkb_rdmux.sv
module lkb_rdmux
    import lkb_pkg::*;
#(
    parameter logic [REV_W-1:0] REV_CODE = 3'd5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] id_q,
    input  lock_t             lock_q,
    output logic [DATA_W-1:0] rd_data
);
    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_ID:   rd_data = id_q;
            ADDR_LOCK: rd_data[1:0] = {lock_q.flt_lock, lock_q.cfg_lock};
            ADDR_REV:  rd_data[REV_W-1:0] = REV_CODE;
            default:   rd_data = '0;
        endcase
    end

    assert_rev_constant_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == ADDR_REV) |-> (rd_data == DATA_W'(REV_CODE)));
    assert_lock_upper_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == ADDR_LOCK) |-> (rd_data[DATA_W-1:2] == '0));
endmodule

// File: rtl/lockable_cfg_bank.sv
module lockable_cfg_bank
    import lkb_pkg::*;
#(
    parameter logic [REV_W-1:0]  REV_CODE = 3'd5,
    parameter logic [ADDR_W-1:0] FLT_LO   = 8'h00,
    parameter logic [ADDR_W-1:0] FLT_HI   = 8'h11,
    parameter logic [ADDR_W-1:0] CFG_LO   = 8'h20,
    parameter logic [ADDR_W-1:0] CFG_HI   = 8'h6F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              fault_log_hit,
    input  logic [ADDR_W-1:0] nv_addr,
    input  logic              nv_req,
    output logic              nv_permit
);
    wr_t               wr;
    lock_t             lock_q;
    logic [DATA_W-1:0] id_q;
    logic              lock_we;

    assign wr      = '{addr: reg_addr, data: reg_wdata, we: reg_we};
    assign lock_we = reg_we && (reg_addr == ADDR_LOCK);

    lkb_lock_reg u_lock (
        .clk(clk), .rst(rst), .lock_we(lock_we), .lock_wd(reg_wdata[1:0]),
        .flt_trig(fault_log_hit), .lock_q(lock_q)
    );

    lkb_id_reg u_id (
        .clk(clk), .rst(rst), .wr(wr), .cfg_lock(lock_q.cfg_lock), .id_q(id_q)
    );

    lkb_guard #(.FLT_LO(FLT_LO), .FLT_HI(FLT_HI), .CFG_LO(CFG_LO), .CFG_HI(CFG_HI)) u_guard (
        .clk(clk), .rst(rst), .lock_q(lock_q), .nv_addr(nv_addr),
        .nv_req(nv_req), .nv_permit(nv_permit)
    );

    lkb_rdmux #(.REV_CODE(REV_CODE)) u_rd (
        .clk(clk), .rst(rst), .rd_addr(reg_addr), .id_q(id_q),
        .lock_q(lock_q), .rd_data(reg_rdata)
    );
endmodule

// File: tb/lockable_cfg_bank_bench.sv
module lockable_cfg_bank_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] reg_addr = '0, reg_wdata = '0, reg_rdata;
    logic       reg_we = 1'b0, fault_log_hit = 1'b0;
    logic [7:0] nv_addr = '0;
    logic       nv_req = 1'b0, nv_permit;

    int total = 0, bad = 0;
    bit done = 0;
    logic [7:0] m_id;
    logic       m_cfg, m_flt;

    localparam logic [2:0] REV = 3'd5;

    always #4 clk = ~clk;

    lockable_cfg_bank u_lockable_cfg_bank (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .fault_log_hit(fault_log_hit),
        .nv_addr(nv_addr), .nv_req(nv_req), .nv_permit(nv_permit)
    );

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        case (a)
            8'h5C:   return m_id;
            8'h5D:   return {6'b0, m_flt, m_cfg};
            8'h65:   return {5'b0, REV};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string read_tag(input logic [7:0] a);
        case (a)
            8'h5C:   return m_cfg ? "R3" : "R2";
            8'h5D:   return "R4";
            8'h65:   return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic logic exp_permit(input logic [7:0] a, input logic req);
        if (!req) return 1'b0;
        if (a <= 8'h11 && m_flt) return 1'b0;
        if (a >= 8'h20 && a <= 8'h6F && a != 8'h5D && m_cfg) return 1'b0;
        return 1'b1;
    endfunction

    function automatic string permit_tag(input logic [7:0] a);
        if (a <= 8'h11) return "R8";
        if (a >= 8'h20 && a <= 8'h6F) return "R9";
        return "R10";
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Apply at negedge, check pre-edge view 2 ns later, advance model after the edge.
    task automatic step(input logic [7:0] a, input logic [7:0] d, input logic we,
                        input logic trig, input logic [7:0] na, input logic nr);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = we; fault_log_hit = trig;
        nv_addr = na; nv_req = nr;
        #2;
        check(read_tag(a), reg_rdata, exp_read(a));
        check(permit_tag(na), {7'b0, nv_permit}, {7'b0, exp_permit(na, nr)});
        @(posedge clk);
        if (we && a == 8'h5C && !m_cfg) m_id = d;
        if (we && a == 8'h5D) begin
            m_cfg = m_cfg ^ d[0];
            m_flt = m_flt ^ d[1];
        end
        if (trig) m_flt = 1'b1;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_id = 8'h00; m_cfg = 1'b0; m_flt = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1 reset state
        @(negedge clk); reg_addr = 8'h5C; #2; check("R1", reg_rdata, 8'h00);
        reg_addr = 8'h5D; #2; check("R1", reg_rdata, 8'h00);

        // R2 open write then read
        step(8'h5C, 8'hA7, 1, 0, 8'h05, 1);
        step(8'h5C, 8'h00, 0, 0, 8'h30, 1);
        // R6 write to revision ignored
        step(8'h65, 8'hFF, 1, 0, 8'h80, 1);
        step(8'h65, 8'h00, 0, 0, 8'h00, 0);
        // R4 set cfg lock, R3 locked ID write ignored, R9 refusal
        step(8'h5D, 8'hFD, 1, 0, 8'h40, 1);
        step(8'h5C, 8'h3C, 1, 0, 8'h40, 1);
        step(8'h5C, 8'h00, 0, 0, 8'h5D, 1);
        // R4 lock register still writable while locked; zero keeps
        step(8'h5D, 8'h00, 1, 0, 8'h6F, 1);
        step(8'h5D, 8'h00, 0, 0, 8'h70, 1);
        // R5 strobe and toggle of bit 1 in the same cycle
        step(8'h5D, 8'h02, 1, 1, 8'h11, 1);
        step(8'h5D, 8'h00, 0, 0, 8'h11, 1);
        // R8 clear flag by toggle then range open
        step(8'h5D, 8'h03, 1, 0, 8'h00, 1);
        step(8'h5D, 8'h00, 0, 0, 8'h00, 1);
        step(8'h5C, 8'h00, 0, 0, 8'h12, 1);
        // R7 unmapped address
        step(8'hFF, 8'h55, 1, 0, 8'h11, 0);

        for (int i = 0; i < 600; i++) begin
            logic [7:0] a, na;
            int sel;
            sel = $urandom_range(0, 7);
            a = (sel < 3) ? 8'h5C : (sel < 5) ? 8'h5D : (sel == 5) ? 8'h65 : 8'($urandom);
            sel = $urandom_range(0, 3);
            na = (sel == 0) ? 8'($urandom_range(0, 8'h13)) :
                 (sel == 1) ? 8'h5D : 8'($urandom);
            step(a, 8'($urandom), ($urandom_range(0, 1) == 1),
                 ($urandom_range(0, 11) == 0), na, ($urandom_range(0, 3) != 0));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule